// File: doc/BRIEF.md
# Scoreboard-Handshaked Integer Add/Subtract Unit

This block is one integer function unit in a scoreboard-driven core. It performs either an addition or a subtraction. A dispatch stage offers it an instruction with a one-cycle strobe. On that strobe the unit registers its instruction fields: the operation, a carry-in bit, a 12-bit immediate, and a flag that picks either the immediate or the second register operand.

The unit then raises a read request and waits for an external arbiter to grant it. The grant tells the unit that the operand buses carry its values. The unit samples both buses on that edge. It spends exactly one internal summing cycle, then raises a write request. It holds the result steady until the arbiter returns a write grant.

All state sits in edge-triggered flops; there are no set/reset latches. The busy flag comes from a register. It therefore rises one clock after the accepting issue edge, and no combinational path runs from the issue strobe to busy.

Back-pressure rules:
- The issue strobe is accepted only while busy is low. An issue that arrives while busy is high is dropped, and the dispatch stage must retry.
- A request stays asserted until its grant is seen on a clock edge.
- A grant that arrives while its own request is low has no effect.

Top module: `fu_add_unit`

## Requirements
- R1: While reset is active, and on the first cycle after it, busy_o, rd_req_o and wr_req_o are 0 and result_o is all zeros.
- R2: When issue_i is high on an edge while busy_o is low, the unit registers sub_i, cin_i, use_imm_i and imm_i, and rd_req_o is 1 from the next cycle on.
- R3: busy_o rises exactly one cycle after an accepted issue. It stays 1 until the cycle after a write grant is accepted.
- R4: When rd_grant_i is high on an edge while rd_req_o is 1, opa_i and opb_i are sampled. Then follows one cycle with both requests low and busy 1, and after it wr_req_o is 1.
- R5: With sub=0, the result is A + B2 + cin modulo 2^W.
- R6: With sub=1, the result is A - B2 modulo 2^W, and cin is ignored.
- R7: B2 is imm_i sign-extended (bit 11 is the sign) to W bits when use_imm=1, and the sampled opb_i when use_imm=0.
- R8: While wr_req_o is 1 and wr_grant_i is low, wr_req_o and result_o hold. When wr_grant_i is high on an edge while wr_req_o is 1, the next cycle shows busy_o=0, wr_req_o=0 and result_o all zeros.
- R9: A rd_grant_i or wr_grant_i that is high while its own request is low changes no output and no captured value.
- R10: An issue_i pulse while busy_o is 1 is ignored. This includes the cycle in which the write grant is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction issue strobe |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| cin_i | input | 1 | Carry-in for add |
| use_imm_i | input | 1 | 1 = second operand from the immediate |
| imm_i | input | 12 | Signed immediate |
| busy_o | output | 1 | Unit occupied |
| rd_req_o | output | 1 | Operand read request |
| rd_grant_i | input | 1 | Operand read grant from the arbiter |
| opa_i | input | W | First operand bus |
| opb_i | input | W | Second operand bus |
| wr_req_o | output | 1 | Result write request |
| wr_grant_i | input | 1 | Result write grant from the arbiter |
| result_o | output | W | Result, valid while wr_req_o is 1 |

## Verification
The critical overlap is a new issue strobe that lands in the same cycle as the write grant that frees the unit. The unit must drop that strobe, because busy is still registered high on that edge.

The bench provokes this overlap by driving issue, both grants and the operand buses at random on every cycle. The same random traffic also produces grants with no request pending.

A behavioural reference decides, each cycle, whether the unit should accept or drop each of these events. The unit's busy, requests and result are compared against it every cycle. An extra check tagged with the requirement runs right after each dropped issue or stray grant.

// File: rtl/fu_add_pkg.sv
package fu_add_pkg;
  localparam int IMM_W = 12;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RDWAIT = 2'd1,
    ST_SUM    = 2'd2,
    ST_WRWAIT = 2'd3
  } fu_state_e;
endpackage

// File: rtl/fu_add_ctrl.sv
module fu_add_ctrl
  import fu_add_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic rd_grant_i,
  input  logic wr_grant_i,
  output logic issue_take_o,
  output logic rd_take_o,
  output logic sum_en_o,
  output logic wr_take_o,
  output logic busy_o,
  output logic rd_req_o,
  output logic wr_req_o
);
  fu_state_e state_q, state_d;

  always_comb begin
    issue_take_o = (state_q == ST_IDLE) && issue_i;
    rd_take_o    = (state_q == ST_RDWAIT) && rd_grant_i;
    sum_en_o     = (state_q == ST_SUM);
    wr_take_o    = (state_q == ST_WRWAIT) && wr_grant_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (issue_i)    state_d = ST_RDWAIT;
      ST_RDWAIT: if (rd_grant_i) state_d = ST_SUM;
      ST_SUM:                    state_d = ST_WRWAIT;
      ST_WRWAIT: if (wr_grant_i) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign rd_req_o = (state_q == ST_RDWAIT);
  assign wr_req_o = (state_q == ST_WRWAIT);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(issue_i));

  // R4
  sum_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_grant_i) |=> (!rd_req_o && !wr_req_o && busy_o) ##1 wr_req_o);

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_grant_i) |=> wr_req_o);

  // R10
  busy_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && issue_i && !(wr_req_o && wr_grant_i)) |=> busy_o);

  // R9
  stray_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !issue_i) |=> !busy_o);
endmodule

// File: rtl/fu_add_core.sv
module fu_add_core #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;
  logic         c_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c_eff = sub_i ? 1'b1 : cin_i;
    sum_o = a_i + b_eff + {{(W-1){1'b0}}, c_eff};
  end
endmodule

// File: rtl/fu_add_dpath.sv
module fu_add_dpath
  import fu_add_pkg::*;
#(
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_take_i,
  input  logic             rd_take_i,
  input  logic             sum_en_i,
  input  logic             wr_take_i,
  input  logic             wr_req_i,
  input  logic             sub_i,
  input  logic             cin_i,
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  output logic [W-1:0]     result_o
);
  logic             f_sub, f_cin, f_use_imm;
  logic [IMM_W-1:0] f_imm;
  logic [W-1:0]     a_q, b_q, imm_ext, b_sel, sum;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_take_i) begin
      f_sub     <= 1'b0;
      f_cin     <= 1'b0;
      f_use_imm <= 1'b0;
      f_imm     <= '0;
    end else if (issue_take_i) begin
      f_sub     <= sub_i;
      f_cin     <= cin_i;
      f_use_imm <= use_imm_i;
      f_imm     <= imm_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_take_i) begin
      a_q <= '0;
      b_q <= '0;
    end else if (rd_take_i) begin
      a_q <= opa_i;
      b_q <= opb_i;
    end
  end

  generate
    if (W > IMM_W) begin : g_sext
      assign imm_ext = {{(W-IMM_W){f_imm[IMM_W-1]}}, f_imm};
    end else begin : g_trunc
      assign imm_ext = f_imm[W-1:0];
    end
  endgenerate

  assign b_sel = f_use_imm ? imm_ext : b_q;

  fu_add_core #(.W(W)) u_core (
    .a_i   (a_q),
    .b_i   (b_sel),
    .sub_i (f_sub),
    .cin_i (f_cin),
    .sum_o (sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || wr_take_i) result_o <= '0;
    else if (sum_en_i)       result_o <= sum;
  end

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && !wr_take_i) |=> $stable(result_o));

  // R8
  result_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take_i |=> (result_o == '0));
endmodule

// File: rtl/fu_add_unit.sv
module fu_add_unit
  import fu_add_pkg::*;
#(
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic             sub_i,
  input  logic             cin_i,
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             busy_o,
  output logic             rd_req_o,
  input  logic             rd_grant_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  output logic             wr_req_o,
  input  logic             wr_grant_i,
  output logic [W-1:0]     result_o
);
  logic issue_take, rd_take, sum_en, wr_take;

  fu_add_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_i      (issue_i),
    .rd_grant_i   (rd_grant_i),
    .wr_grant_i   (wr_grant_i),
    .issue_take_o (issue_take),
    .rd_take_o    (rd_take),
    .sum_en_o     (sum_en),
    .wr_take_o    (wr_take),
    .busy_o       (busy_o),
    .rd_req_o     (rd_req_o),
    .wr_req_o     (wr_req_o)
  );

  fu_add_dpath #(.W(W)) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_take_i (issue_take),
    .rd_take_i    (rd_take),
    .sum_en_i     (sum_en),
    .wr_take_i    (wr_take),
    .wr_req_i     (wr_req_o),
    .sub_i        (sub_i),
    .cin_i        (cin_i),
    .use_imm_i    (use_imm_i),
    .imm_i        (imm_i),
    .opa_i        (opa_i),
    .opb_i        (opb_i),
    .result_o     (result_o)
  );
endmodule

// File: tb/fu_add_unit_tb.sv
`timescale 1ns/1ps
module fu_add_unit_tb;
  localparam int W = 64;
  localparam int CYCLES = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_i = 0, sub_i = 0, cin_i = 0, use_imm_i = 0;
  logic [11:0] imm_i = '0;
  logic rd_grant_i = 0, wr_grant_i = 0;
  logic [W-1:0] opa_i = '0, opb_i = '0;
  logic busy_o, rd_req_o, wr_req_o;
  logic [W-1:0] result_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fu_add_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .sub_i(sub_i), .cin_i(cin_i),
    .use_imm_i(use_imm_i), .imm_i(imm_i), .busy_o(busy_o), .rd_req_o(rd_req_o),
    .rd_grant_i(rd_grant_i), .opa_i(opa_i), .opb_i(opb_i), .wr_req_o(wr_req_o),
    .wr_grant_i(wr_grant_i), .result_o(result_o)
  );

  // behavioural reference: phase 0 idle, 1 wait read, 2 sum, 3 wait write
  int m_phase = 0;
  bit m_sub, m_cin, m_imm_sel;
  logic [11:0] m_imm;
  logic [W-1:0] m_a, m_b, m_res, m_prev_res;
  bit ev_ign_issue, ev_stray, ev_hold;
  int n_ops = 0;

  always @(posedge clk) begin
    logic [W-1:0] b2;
    ev_ign_issue = 0;
    ev_stray = 0;
    ev_hold = 0;
    m_prev_res = m_res;
    if (!rst_n) begin
      m_phase = 0; m_sub = 0; m_cin = 0; m_imm_sel = 0; m_imm = '0;
      m_a = '0; m_b = '0; m_res = '0;
    end else begin
      if (issue_i && m_phase != 0) ev_ign_issue = 1;
      if ((rd_grant_i && m_phase != 1) || (wr_grant_i && m_phase != 3)) ev_stray = 1;
      case (m_phase)
        0: if (issue_i) begin
             m_sub = sub_i; m_cin = cin_i; m_imm_sel = use_imm_i; m_imm = imm_i;
             m_phase = 1;
           end
        1: if (rd_grant_i) begin
             m_a = opa_i; m_b = opb_i; m_phase = 2;
           end
        2: begin
             b2 = m_imm_sel ? W'($signed(m_imm)) : m_b;
             if (m_sub) m_res = m_a - b2;
             else       m_res = m_a + b2 + W'(m_cin);
             m_phase = 3;
           end
        default: if (wr_grant_i) begin
             m_phase = 0; m_sub = 0; m_cin = 0; m_imm_sel = 0; m_imm = '0;
             m_a = '0; m_b = '0; m_res = '0; n_ops++;
           end else ev_hold = 1;
      endcase
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pick_op();
    int s;
    s = $urandom_range(0, 5);
    case (s)
      0: return '0;
      1: return '1;
      2: return {1'b1, {(W-1){1'b0}}};
      3: return W'(1);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic compare_all();
    string rtag;
    chk("R3 busy", W'(busy_o), W'(m_phase != 0));
    chk("R2 rd_req", W'(rd_req_o), W'(m_phase == 1));
    chk("R4 wr_req", W'(wr_req_o), W'(m_phase == 3));
    if (m_phase == 3) begin
      rtag = m_sub ? "R6 sub result" : "R5 add result";
      if (m_imm_sel) rtag = {rtag, " R7 imm"};
      else           rtag = {rtag, " R7 reg"};
      chk(rtag, result_o, m_res);
    end else begin
      chk("R8 result zero outside write phase", result_o, m_res);
    end
    if (ev_hold) chk("R8 result held", result_o, m_prev_res);
    if (ev_ign_issue) chk("R10 issue while busy", W'({busy_o, rd_req_o, wr_req_o}),
                          W'({m_phase != 0, m_phase == 1, m_phase == 3}));
    if (ev_stray) chk("R9 stray grant", W'({busy_o, rd_req_o, wr_req_o}),
                      W'({m_phase != 0, m_phase == 1, m_phase == 3}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 busy in reset", W'(busy_o), '0);
    chk("R1 rd_req in reset", W'(rd_req_o), '0);
    chk("R1 wr_req in reset", W'(wr_req_o), '0);
    chk("R1 result in reset", result_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", W'({busy_o, rd_req_o, wr_req_o}), '0);
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      issue_i    = ($urandom_range(0, 99) < 40);
      sub_i      = $urandom_range(0, 1);
      cin_i      = $urandom_range(0, 1);
      use_imm_i  = $urandom_range(0, 1);
      imm_i      = 12'($urandom);
      rd_grant_i = ($urandom_range(0, 99) < 35);
      wr_grant_i = ($urandom_range(0, 99) < 35);
      opa_i      = pick_op();
      opb_i      = pick_op();
      @(negedge clk);
      compare_all();
    end
    chk("R4 operations completed", W'(n_ops > 50), W'(1));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule